// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a distributed shared-memory machine and keeps coherence for the memory blocks that live there. For every block it records whether no cache holds it (uncached), one or more caches hold read-only copies (shared), or exactly one cache holds a writable copy (exclusive). Alongside that state it keeps a bit-vector of sharers and the identity of the owner. Nodes send it read-miss, write-miss and writeback messages over a point-to-point network instead of a broadcast bus. The controller answers with data replies, multicast invalidates to sharers, and fetch requests to the current owner. It also keeps its backing memory up to date.

Requests enter a small in-order queue and are handled strictly one at a time. The order in which the controller serves requests is therefore the global order of conflicting writes to its blocks. When a block is exclusive somewhere else, the controller sends a fetch to the owner and waits for the fetch response. It completes the request only after that, and everything queued behind it stays held.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached with no sharers, block b's memory word is 32'h5EED0000 + 273*b, the outputs rep_valid, inv_valid and fet_valid are low, and req_ready is high.
- R2: A read miss (req_kind 0) to an uncached block returns one rep_valid pulse carrying the memory word to the requester. The block becomes shared with the requester as its only sharer.
- R3: A write miss (req_kind 1) to an uncached block returns the memory word with no invalidate. The block becomes exclusive with the requester as owner.
- R4: A read miss to a shared block returns the memory word and adds the requester to the sharer vector, keeping the earlier sharers.
- R5: A write miss to a shared block returns the memory word. In the same cycle it raises inv_valid with inv_mask equal to the sharer vector with the requester's bit cleared, and raises it only when that mask is non-zero. The block then becomes exclusive to the requester.
- R6: A read miss to an exclusive block sends one fetch to the owner with fet_inval low and waits for fr_valid. The returned word is written to memory and replied to the requester. The block becomes shared by the old owner and the requester.
- R7: A write miss to an exclusive block sends one fetch to the owner with fet_inval high. The returned word is written to memory and replied to the requester, who becomes the new owner while the block stays exclusive.
- R8: A writeback (req_kind 2) from the owner of an exclusive block writes its data to memory and makes the block uncached, with no reply. A later read miss is then served from memory without a fetch.
- R9: A writeback from a node that is not the owner of an exclusive block changes neither memory nor directory state.
- R10: Requests are served one at a time in arrival order. While a fetch is outstanding no reply is issued, and queued requests wait. req_ready is low while Q_DEPTH requests (the one being served included) are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request queue has room |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_node | input | clog2(N_NODES) | Requesting node |
| req_blk | input | clog2(N_BLOCKS) | Target block |
| req_data | input | DATA_W | Writeback data |
| rep_valid | output | 1 | Data reply pulse |
| rep_node | output | clog2(N_NODES) | Reply destination |
| rep_blk | output | clog2(N_BLOCKS) | Reply block |
| rep_data | output | DATA_W | Reply data |
| inv_valid | output | 1 | Invalidate multicast pulse |
| inv_mask | output | N_NODES | Nodes to invalidate |
| inv_blk | output | clog2(N_BLOCKS) | Block to invalidate |
| fet_valid | output | 1 | Fetch request pulse to owner |
| fet_node | output | clog2(N_NODES) | Owner being fetched from |
| fet_blk | output | clog2(N_BLOCKS) | Block fetched |
| fet_inval | output | 1 | Owner must also invalidate (write miss) |
| fr_valid | input | 1 | Fetch response from owner |
| fr_data | input | DATA_W | Fetched data |

## Verification
On every cycle the assertions check the consistency of each directory entry. An uncached entry has no sharers, a shared entry has at least one, and an exclusive entry's sharer vector is exactly the owner's bit. They also check that an invalidate never names the requester and is never empty, that fetches and replies stay apart, and that no reply leaves while a fetch is outstanding. Only the bench scenarios can show that data reaches the right node with the right value. They also show that sharer sets build up across requests, that memory holds fetched and written-back words, that ignored writebacks leave no trace, and that queued requests complete in arrival order.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    RK_READ  = 2'd0,
    RK_WRITE = 2'd1,
    RK_WBACK = 2'd2
  } rkind_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_WAIT = 1'b1
  } phase_e;

  function automatic logic [31:0] seed_word(input int unsigned blk);
    return 32'h5EED_0000 + blk * 32'd273;
  endfunction

endpackage

// File: rtl/dir_req_fifo.sv
module dir_req_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = slots[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      if (push && !full) begin
        slots[wptr] <= push_data;
        wptr        <= wrap_inc(wptr);
      end
      if (pop && !empty) rptr <= wrap_inc(rptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0) |-> !push);

endmodule

// File: rtl/dir_state_store.sv
module dir_state_store
  import dir_pkg::*;
#(
  parameter int N_NODES  = 4,
  parameter int N_BLOCKS = 8,
  parameter int DATA_W   = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(N_BLOCKS)-1:0] rd_blk,
  output dstate_e                     rd_st,
  output logic [N_NODES-1:0]          rd_shr,
  output logic [$clog2(N_NODES)-1:0]  rd_own,
  output logic [DATA_W-1:0]           rd_data,
  input  logic                        upd_en,
  input  logic [$clog2(N_BLOCKS)-1:0] upd_blk,
  input  dstate_e                     upd_st,
  input  logic [N_NODES-1:0]          upd_shr,
  input  logic [$clog2(N_NODES)-1:0]  upd_own,
  input  logic                        mem_we,
  input  logic [DATA_W-1:0]           mem_wdata
);
  localparam int NID_W = $clog2(N_NODES);

  dstate_e            st_q   [N_BLOCKS];
  logic [N_NODES-1:0] shr_q  [N_BLOCKS];
  logic [NID_W-1:0]   own_q  [N_BLOCKS];
  logic [DATA_W-1:0]  mem_q  [N_BLOCKS];

  assign rd_st   = st_q[rd_blk];
  assign rd_shr  = shr_q[rd_blk];
  assign rd_own  = own_q[rd_blk];
  assign rd_data = mem_q[rd_blk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < N_BLOCKS; b++) begin
        st_q[b]  <= DS_UNC;
        shr_q[b] <= '0;
        own_q[b] <= '0;
        mem_q[b] <= DATA_W'(seed_word(b));
      end
    end else begin
      if (upd_en) begin
        st_q[upd_blk]  <= upd_st;
        shr_q[upd_blk] <= upd_shr;
        own_q[upd_blk] <= upd_own;
      end
      if (mem_we) mem_q[upd_blk] <= mem_wdata;
    end
  end

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_entry_chk
    a_r8_unc_no_sharers: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DS_UNC) |-> (shr_q[b] == '0));
    a_r4_shr_has_sharer: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DS_SHR) |-> (shr_q[b] != '0));
    a_r7_exc_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[b] == DS_EXC) |-> (shr_q[b] == (N_NODES'(1) << own_q[b])));
    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[b] != 2'd3);
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_NODES  = 4,
  parameter int N_BLOCKS = 8,
  parameter int DATA_W   = 32,
  parameter int Q_DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [1:0]                  req_kind,
  input  logic [$clog2(N_NODES)-1:0]  req_node,
  input  logic [$clog2(N_BLOCKS)-1:0] req_blk,
  input  logic [DATA_W-1:0]           req_data,
  output logic                        rep_valid,
  output logic [$clog2(N_NODES)-1:0]  rep_node,
  output logic [$clog2(N_BLOCKS)-1:0] rep_blk,
  output logic [DATA_W-1:0]           rep_data,
  output logic                        inv_valid,
  output logic [N_NODES-1:0]          inv_mask,
  output logic [$clog2(N_BLOCKS)-1:0] inv_blk,
  output logic                        fet_valid,
  output logic [$clog2(N_NODES)-1:0]  fet_node,
  output logic [$clog2(N_BLOCKS)-1:0] fet_blk,
  output logic                        fet_inval,
  input  logic                        fr_valid,
  input  logic [DATA_W-1:0]           fr_data
);
  localparam int NID_W = $clog2(N_NODES);
  localparam int BLK_W = $clog2(N_BLOCKS);
  localparam int REQ_W = 2 + NID_W + BLK_W + DATA_W;

  function automatic logic [N_NODES-1:0] node_bit(input logic [NID_W-1:0] n);
    return N_NODES'(1) << n;
  endfunction

  function automatic logic [N_NODES-1:0] inv_targets(input logic [N_NODES-1:0] shr,
                                                     input logic [NID_W-1:0]   req);
    return shr & ~node_bit(req);
  endfunction

  // request queue
  logic             q_empty, q_full, q_pop;
  logic [REQ_W-1:0] q_head;

  dir_req_fifo #(.W(REQ_W), .DEPTH(Q_DEPTH)) i_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_valid),
    .push_data ({req_kind, req_node, req_blk, req_data}),
    .pop       (q_pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  assign req_ready = !q_full;

  rkind_e             hd_kind;
  logic [NID_W-1:0]   hd_node;
  logic [BLK_W-1:0]   hd_blk;
  logic [DATA_W-1:0]  hd_data;
  assign hd_kind = rkind_e'(q_head[REQ_W-1 -: 2]);
  assign hd_node = q_head[DATA_W+BLK_W +: NID_W];
  assign hd_blk  = q_head[DATA_W +: BLK_W];
  assign hd_data = q_head[DATA_W-1:0];

  // directory entries and memory
  dstate_e            cur_st;
  logic [N_NODES-1:0] cur_shr;
  logic [NID_W-1:0]   cur_own;
  logic [DATA_W-1:0]  cur_mem;
  logic               upd_en, mem_we;
  dstate_e            upd_st;
  logic [N_NODES-1:0] upd_shr;
  logic [NID_W-1:0]   upd_own;
  logic [DATA_W-1:0]  mem_wdata;

  dir_state_store #(.N_NODES(N_NODES), .N_BLOCKS(N_BLOCKS), .DATA_W(DATA_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_blk    (hd_blk),
    .rd_st     (cur_st),
    .rd_shr    (cur_shr),
    .rd_own    (cur_own),
    .rd_data   (cur_mem),
    .upd_en    (upd_en),
    .upd_blk   (hd_blk),
    .upd_st    (upd_st),
    .upd_shr   (upd_shr),
    .upd_own   (upd_own),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

  // named internal events
  phase_e ph_q, ph_d;
  logic   ev_serve, ev_fetch_go, ev_fetch_done, ev_wb_take;
  assign ev_serve      = (ph_q == PH_IDLE) && !q_empty;
  assign ev_fetch_go   = ev_serve && (cur_st == DS_EXC) &&
                         (hd_kind == RK_READ || hd_kind == RK_WRITE);
  assign ev_fetch_done = (ph_q == PH_WAIT) && fr_valid;
  assign ev_wb_take    = ev_serve && (hd_kind == RK_WBACK) &&
                         (cur_st == DS_EXC) && (cur_own == hd_node);

  logic               rep_v_d, inv_v_d, fet_v_d, fet_inv_d;
  logic [DATA_W-1:0]  rep_data_d;
  logic [N_NODES-1:0] inv_mask_d;

  always_comb begin
    ph_d       = ph_q;
    q_pop      = 1'b0;
    upd_en     = 1'b0;
    upd_st     = cur_st;
    upd_shr    = cur_shr;
    upd_own    = cur_own;
    mem_we     = 1'b0;
    mem_wdata  = hd_data;
    rep_v_d    = 1'b0;
    rep_data_d = cur_mem;
    inv_v_d    = 1'b0;
    inv_mask_d = '0;
    fet_v_d    = 1'b0;
    fet_inv_d  = 1'b0;
    if (ev_serve) begin
      case (hd_kind)
        RK_READ: begin
          case (cur_st)
            DS_UNC: begin
              rep_v_d = 1'b1; q_pop = 1'b1; upd_en = 1'b1;
              upd_st  = DS_SHR; upd_shr = node_bit(hd_node);
            end
            DS_SHR: begin
              rep_v_d = 1'b1; q_pop = 1'b1; upd_en = 1'b1;
              upd_st  = DS_SHR; upd_shr = cur_shr | node_bit(hd_node);
            end
            default: begin
              fet_v_d = 1'b1; fet_inv_d = 1'b0; ph_d = PH_WAIT;
            end
          endcase
        end
        RK_WRITE: begin
          case (cur_st)
            DS_UNC: begin
              rep_v_d = 1'b1; q_pop = 1'b1; upd_en = 1'b1;
              upd_st  = DS_EXC; upd_shr = node_bit(hd_node); upd_own = hd_node;
            end
            DS_SHR: begin
              rep_v_d    = 1'b1; q_pop = 1'b1; upd_en = 1'b1;
              inv_mask_d = inv_targets(cur_shr, hd_node);
              inv_v_d    = (inv_mask_d != '0);
              upd_st     = DS_EXC; upd_shr = node_bit(hd_node); upd_own = hd_node;
            end
            default: begin
              fet_v_d = 1'b1; fet_inv_d = 1'b1; ph_d = PH_WAIT;
            end
          endcase
        end
        RK_WBACK: begin
          q_pop = 1'b1;
          if (ev_wb_take) begin
            mem_we = 1'b1; mem_wdata = hd_data; upd_en = 1'b1;
            upd_st = DS_UNC; upd_shr = '0;
          end
        end
        default: q_pop = 1'b1;
      endcase
    end else if (ev_fetch_done) begin
      mem_we     = 1'b1;
      mem_wdata  = fr_data;
      rep_v_d    = 1'b1;
      rep_data_d = fr_data;
      q_pop      = 1'b1;
      upd_en     = 1'b1;
      ph_d       = PH_IDLE;
      if (hd_kind == RK_READ) begin
        upd_st  = DS_SHR;
        upd_shr = node_bit(cur_own) | node_bit(hd_node);
      end else begin
        upd_st  = DS_EXC;
        upd_shr = node_bit(hd_node);
        upd_own = hd_node;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      rep_valid <= 1'b0;
      rep_node  <= '0;
      rep_blk   <= '0;
      rep_data  <= '0;
      inv_valid <= 1'b0;
      inv_mask  <= '0;
      inv_blk   <= '0;
      fet_valid <= 1'b0;
      fet_node  <= '0;
      fet_blk   <= '0;
      fet_inval <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      rep_valid <= rep_v_d;
      rep_node  <= hd_node;
      rep_blk   <= hd_blk;
      rep_data  <= rep_data_d;
      inv_valid <= inv_v_d;
      inv_mask  <= inv_mask_d;
      inv_blk   <= hd_blk;
      fet_valid <= fet_v_d;
      fet_node  <= cur_own;
      fet_blk   <= hd_blk;
      fet_inval <= fet_inv_d;
    end
  end

  a_r5_inv_skips_req: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (rep_valid && !inv_mask[rep_node]));
  a_r5_inv_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_mask != '0));
  a_r6_fetch_enters_wait: assert property (@(posedge clk) disable iff (!rst_n)
    fet_valid |-> (ph_q == PH_WAIT && !rep_valid));
  a_r10_quiet_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT) |-> !rep_valid);
  a_r10_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_WAIT) && !fr_valid) |=> $stable(q_head));
  a_r8_wb_no_reply: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_take |=> !rep_valid);

endmodule

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NN = 4;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_node = '0;
  logic [2:0]  req_blk = '0;
  logic [31:0] req_data = '0;
  logic        rep_valid;
  logic [1:0]  rep_node;
  logic [2:0]  rep_blk;
  logic [31:0] rep_data;
  logic        inv_valid;
  logic [3:0]  inv_mask;
  logic [2:0]  inv_blk;
  logic        fet_valid;
  logic [1:0]  fet_node;
  logic [2:0]  fet_blk;
  logic        fet_inval;
  logic        fr_valid = 1'b0;
  logic [31:0] fr_data = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_home_ctrl #(.N_NODES(NN), .N_BLOCKS(NB), .DATA_W(32), .Q_DEPTH(4)) i_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_node(req_node), .req_blk(req_blk), .req_data(req_data),
    .rep_valid(rep_valid), .rep_node(rep_node), .rep_blk(rep_blk), .rep_data(rep_data),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_blk(inv_blk),
    .fet_valid(fet_valid), .fet_node(fet_node), .fet_blk(fet_blk), .fet_inval(fet_inval),
    .fr_valid(fr_valid), .fr_data(fr_data)
  );

  function automatic logic [31:0] init_val(input int b);
    return 32'h5EED0000 + 32'(b) * 32'd273;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] k, input logic [1:0] n, input logic [2:0] b,
                      input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_node = n; req_blk = b; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rep(input logic [1:0] n, input logic [2:0] b, input logic [31:0] d,
                            input logic [3:0] mask, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (fet_valid) chk(1'b0, {tag, " unexpected fetch"}, {30'd0, fet_node}, 32'd0);
      if (rep_valid) begin
        seen = 1'b1;
        chk(rep_node == n && rep_blk == b, {tag, " reply dest"},
            {24'd0, 3'd0, rep_blk, rep_node}, {24'd0, 3'd0, b, n});
        chk(rep_data == d, {tag, " reply data"}, rep_data, d);
        chk((inv_valid ? inv_mask : 4'd0) == mask && (!inv_valid || inv_blk == b),
            {tag, " invalidate"}, {28'd0, inv_valid ? inv_mask : 4'd0}, {28'd0, mask});
      end else @(negedge clk);
    end
    if (!seen) chk(1'b0, {tag, " reply missing"}, 32'd0, 32'd1);
    else @(negedge clk);
  endtask

  task automatic expect_fetch(input logic [1:0] n, input logic [2:0] b, input bit inval,
                              input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (rep_valid) chk(1'b0, {tag, " reply before fetch"}, 32'd1, 32'd0);
      if (fet_valid) begin
        seen = 1'b1;
        chk(fet_node == n && fet_blk == b && fet_inval == inval, {tag, " fetch"},
            {24'd0, fet_inval, fet_blk, 2'd0, fet_node}, {24'd0, inval, b, 2'd0, n});
      end else @(negedge clk);
    end
    if (!seen) chk(1'b0, {tag, " fetch missing"}, 32'd0, 32'd1);
    else @(negedge clk);
  endtask

  task automatic give_fr(input logic [31:0] d);
    @(negedge clk);
    fr_valid = 1'b1; fr_data = d;
    @(negedge clk);
    fr_valid = 1'b0;
  endtask

  task automatic expect_quiet(input int cycles, input string tag);
    bit any = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      if (rep_valid || fet_valid || inv_valid) any = 1'b1;
      @(negedge clk);
    end
    chk(!any, {tag, " no output"}, {31'd0, any}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!rep_valid && !inv_valid && !fet_valid, "R1 outputs idle",
        {29'd0, rep_valid, inv_valid, fet_valid}, 32'd0);
    chk(req_ready, "R1 ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_uncached_read;
    send(2'd0, 2'd0, 3'd0, '0);
    expect_rep(2'd0, 3'd0, init_val(0), 4'b0000, "R2 read uncached");
    send(2'd1, 2'd1, 3'd0, '0);
    expect_rep(2'd1, 3'd0, init_val(0), 4'b0001, "R2 R5 sole sharer invalidated");
  endtask

  task automatic t_shared_build;
    send(2'd0, 2'd0, 3'd1, '0);
    expect_rep(2'd0, 3'd1, init_val(1), 4'b0000, "R4 first sharer");
    send(2'd0, 2'd2, 3'd1, '0);
    expect_rep(2'd2, 3'd1, init_val(1), 4'b0000, "R4 second sharer");
    send(2'd0, 2'd3, 3'd1, '0);
    expect_rep(2'd3, 3'd1, init_val(1), 4'b0000, "R4 third sharer");
    send(2'd1, 2'd2, 3'd1, '0);
    expect_rep(2'd2, 3'd1, init_val(1), 4'b1001, "R5 invalidate excludes requester");
    send(2'd1, 2'd1, 3'd1, '0);
    expect_fetch(2'd2, 3'd1, 1'b1, "R5 R7 exclusive after shared write");
    give_fr(32'h1111_0001);
    expect_rep(2'd1, 3'd1, 32'h1111_0001, 4'b0000, "R7 data from owner");
  endtask

  task automatic t_exclusive_paths;
    send(2'd1, 2'd3, 3'd2, '0);
    expect_rep(2'd3, 3'd2, init_val(2), 4'b0000, "R3 write uncached");
    send(2'd0, 2'd0, 3'd2, '0);
    expect_fetch(2'd3, 3'd2, 1'b0, "R3 R6 read exclusive fetches owner");
    give_fr(32'hD1D1_0002);
    expect_rep(2'd0, 3'd2, 32'hD1D1_0002, 4'b0000, "R6 forwarded data");
    send(2'd1, 2'd1, 3'd2, '0);
    expect_rep(2'd1, 3'd2, 32'hD1D1_0002, 4'b1001, "R6 shared by owner and reader, memory updated");
    send(2'd1, 2'd2, 3'd2, '0);
    expect_fetch(2'd1, 3'd2, 1'b1, "R7 write exclusive fetch");
    give_fr(32'hD2D2_0002);
    expect_rep(2'd2, 3'd2, 32'hD2D2_0002, 4'b0000, "R7 new owner reply");
    send(2'd2, 2'd1, 3'd2, 32'hBAD0_0003);
    expect_quiet(4, "R9 non-owner writeback");
    send(2'd2, 2'd2, 3'd2, 32'hD4D4_0002);
    expect_quiet(4, "R8 owner writeback");
    send(2'd0, 2'd0, 3'd2, '0);
    expect_rep(2'd0, 3'd2, 32'hD4D4_0002, 4'b0000, "R8 R9 uncached after writeback");
    send(2'd2, 2'd3, 3'd2, 32'hBAD0_0005);
    expect_quiet(4, "R9 writeback in shared");
    send(2'd1, 2'd1, 3'd2, '0);
    expect_rep(2'd1, 3'd2, 32'hD4D4_0002, 4'b0001, "R9 memory and sharers unchanged");
  endtask

  task automatic t_ordering;
    send(2'd1, 2'd0, 3'd3, '0);
    expect_rep(2'd0, 3'd3, init_val(3), 4'b0000, "R10 setup owner");
    send(2'd0, 2'd1, 3'd3, '0);
    expect_fetch(2'd0, 3'd3, 1'b0, "R10 fetch pending");
    send(2'd0, 2'd2, 3'd4, '0);
    send(2'd0, 2'd3, 3'd5, '0);
    send(2'd0, 2'd0, 3'd6, '0);
    @(negedge clk);
    chk(!req_ready, "R10 queue full", {31'd0, req_ready}, 32'd0);
    expect_quiet(5, "R10 held during fetch");
    give_fr(32'h0E0E_0003);
    expect_rep(2'd1, 3'd3, 32'h0E0E_0003, 4'b0000, "R10 first in order");
    expect_rep(2'd2, 3'd4, init_val(4), 4'b0000, "R10 second in order");
    expect_rep(2'd3, 3'd5, init_val(5), 4'b0000, "R10 third in order");
    expect_rep(2'd0, 3'd6, init_val(6), 4'b0000, "R10 fourth in order");
    chk(req_ready, "R10 ready again", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_uncached_read();
    t_shared_build();
    t_exclusive_paths();
    t_ordering();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule